// File: doc/BRIEF.md
# Fast Ethernet Receive Framer

This block sits after line decoding and clock recovery in a 100 Mb/s receiver. It takes one recovered bit per clock. While the line idles it sees a run of ones. It looks for the start-of-stream delimiter, and once that delimiter is confirmed it locks the 5-bit code-group boundary. From then on it turns each code group into a 4-bit nibble. The results go to a MAC-side receive interface as a nibble, a data-valid flag, an error flag and a carrier flag. A one-cycle strobe marks each symbol boundary, and the outputs hold their value between strobes.

The two delimiter slots are never forwarded. They become two preamble nibbles. The end-of-stream pair is dropped. Three faults are reported on the same interface: a broken delimiter (false carrier), an undecodable code group, and a frame cut short by idle. The cut-short case also sets a status flag that stays set until a management read clears it.

Each nibble is presented one symbol period after the last bit of its own code group. At that point the next group has arrived and the block knows whether the frame is ending.

Top module: `fe_rx_framer`

## Requirements
- R1: While reset is held, and after it is released until carrier is detected, `rxd` is 0000 and `rx_dv`, `rx_er`, `crs`, `rx_stb` and `prem_end` are 0.
- R2: Bits enter a code group first bit first, with the first bit as the left digit of the codes below. While idle, `crs` rises at the clock edge that samples a bit making the last ten received bits hold two zeros that are not adjacent. `rx_stb` pulses at that edge. `crs` stays high until the frame-ending edge, and `rx_dv` is never high without `crs`.
- R3: At the detection edge, if the last five bits are /J/ = 11000, the next group must be /K/ = 10001. When it is, the edge that samples the last bit of /K/ presents `rxd` = 0101 with `rx_dv` = 1. The next symbol edge presents 0101 again. Neither delimiter code is ever presented.
- R4: Data groups decode as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. The nibble of a group is presented, with `rx_dv` = 1, at the edge that samples the last bit of the following group. `rx_stb` pulses for one cycle at every symbol edge, and all outputs hold between strobes.
- R5: /T/ = 01101 followed by /R/ = 00111 ends the frame. At the /T/ edge the last data nibble is presented. At the edge that samples the last bit of /R/, `rx_dv`, `rx_er` and `crs` drop and `rxd` returns to 0000.
- R6: A group in the data phase that is not one of the sixteen data codes, /T/ or 11111 is presented one symbol later as `rxd` = 0000 with `rx_dv` = 1 and `rx_er` = 1. Decoding continues with the next group.
- R7: An IDLE group 11111 in the data phase presents the pending nibble with `rx_dv` = 1 and `rx_er` = 1, and sets `prem_end`. One symbol later `rx_dv`, `rx_er` and `crs` drop.
- R8: If the group at the detection edge is not /J/, or the group after /J/ is not /K/, the block presents `rxd` = 1110 with `rx_er` = 1 and `rx_dv` = 0 for one symbol period, then drops `crs` and `rx_er`.
- R9: If /T/ is followed by anything other than /R/, the block presents `rxd` = 0000 with `rx_dv` = 1 and `rx_er` = 1 for one symbol period, then drops all flags.
- R10: `prem_end` stays set until a cycle with `stat_rd` high clears it. If a new premature end is detected in the same cycle as the read, the flag stays set.
- R11: On return to idle, bits received before the frame-ending edge no longer count toward carrier detection. One zero arriving just after a frame starts nothing, and a /J/K/ right after /R/ is found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Received serial bit, one per clock |
| stat_rd | input | 1 | Management read of the premature-end flag (clears it) |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Nibble is preamble or frame data |
| rx_er | output | 1 | Error in the current symbol slot |
| crs | output | 1 | Carrier present |
| rx_stb | output | 1 | One-cycle pulse at each symbol boundary |
| prem_end | output | 1 | Sticky premature-end status |

## Verification
Every output change is registered at the clock edge that samples the deciding bit. Carrier and the false-carrier code appear at that edge. A data nibble appears at the edge that samples the final bit of the following group. The drop after an error comes five edges after the error slot. The bench drives each bit on the falling edge and advances a behavioural model by that same bit. On the next falling edge it compares every output with the model, so each expectation is checked in exactly the cycle where it falls due. Stimulus places management reads on chosen bits, including the bit that completes a premature-ending IDLE group.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_FALSE_CS = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHK_K = 3'd1,
        ST_DATA  = 3'd2,
        ST_CHK_R = 3'd3,
        ST_FLUSH = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic             is_data;
        logic [NIB_W-1:0] nib;
        logic             is_j;
        logic             is_k;
        logic             is_t;
        logic             is_r;
        logic             is_idle;
    } sym_class_t;

endpackage

// File: rtl/fe_rx_shift.sv
module fe_rx_shift #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    input  logic             clr_i,
    output logic [SYM_W-1:0] sym_o,
    output logic             carrier_o
);
    localparam int WIN_W = 2 * SYM_W;

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_d;
    logic [WIN_W-1:0] win_nxt;

    always_comb begin
        win_nxt   = {win_q[WIN_W-2:0], bit_i};
        sym_o     = win_nxt[SYM_W-1:0];
        win_d     = clr_i ? {WIN_W{1'b1}} : win_nxt;
        carrier_o = 1'b0;
        for (int i = 0; i < WIN_W; i++) begin
            for (int j = i + 2; j < WIN_W; j++) begin
                if (!win_nxt[i] && !win_nxt[j]) begin
                    carrier_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= {WIN_W{1'b1}};
        end else begin
            win_q <= win_d;
        end
    end

endmodule

// File: rtl/fe_rx_symdec.sv
module fe_rx_symdec
    import fe_rx_pkg::*;
(
    input  logic [CG_W-1:0] code_i,
    output sym_class_t      cls_o
);
    always_comb begin
        cls_o         = '0;
        cls_o.is_j    = (code_i == CG_J);
        cls_o.is_k    = (code_i == CG_K);
        cls_o.is_t    = (code_i == CG_T);
        cls_o.is_r    = (code_i == CG_R);
        cls_o.is_idle = (code_i == CG_IDLE);
        cls_o.is_data = 1'b1;
        case (code_i)
            5'b11110: cls_o.nib = 4'h0;
            5'b01001: cls_o.nib = 4'h1;
            5'b10100: cls_o.nib = 4'h2;
            5'b10101: cls_o.nib = 4'h3;
            5'b01010: cls_o.nib = 4'h4;
            5'b01011: cls_o.nib = 4'h5;
            5'b01110: cls_o.nib = 4'h6;
            5'b01111: cls_o.nib = 4'h7;
            5'b10010: cls_o.nib = 4'h8;
            5'b10011: cls_o.nib = 4'h9;
            5'b10110: cls_o.nib = 4'hA;
            5'b10111: cls_o.nib = 4'hB;
            5'b11010: cls_o.nib = 4'hC;
            5'b11011: cls_o.nib = 4'hD;
            5'b11100: cls_o.nib = 4'hE;
            5'b11101: cls_o.nib = 4'hF;
            default: begin
                cls_o.is_data = 1'b0;
                cls_o.nib     = '0;
            end
        endcase
    end

endmodule

// File: rtl/fe_rx_sticky.sv
module fe_rx_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;
    logic flag_d;

    always_comb begin
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer
    import fe_rx_pkg::*;
#(
    parameter int SYM_W = CG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             stat_rd,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             crs,
    output logic             rx_stb,
    output logic             prem_end
);
    localparam int CNT_W = $clog2(SYM_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SYM_W - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [NIB_W-1:0] pend;
        logic             perr;
        logic [NIB_W-1:0] rxd;
        logic             dv;
        logic             er;
        logic             crs;
        logic             stb;
    } frm_t;

    frm_t             frm_q;
    frm_t             frm_d;
    logic [SYM_W-1:0] sym;
    logic             carrier;
    sym_class_t       cls;
    logic             clr_win;
    logic             prem_set;
    logic             sym_edge;

    fe_rx_shift #(.SYM_W(SYM_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_i    (rx_bit),
        .clr_i    (clr_win),
        .sym_o    (sym),
        .carrier_o(carrier)
    );

    fe_rx_symdec u_dec (
        .code_i(sym),
        .cls_o (cls)
    );

    fe_rx_sticky u_prem (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (prem_set),
        .clr_i (stat_rd),
        .flag_o(prem_end)
    );

    always_comb begin
        frm_d     = frm_q;
        frm_d.stb = 1'b0;
        clr_win   = 1'b0;
        prem_set  = 1'b0;
        sym_edge  = (frm_q.cnt == LAST_BIT);
        if (frm_q.st == ST_IDLE) begin
            frm_d.cnt = '0;
            if (carrier) begin
                frm_d.stb = 1'b1;
                frm_d.crs = 1'b1;
                frm_d.dv  = 1'b0;
                if (cls.is_j) begin
                    frm_d.st  = ST_CHK_K;
                    frm_d.rxd = '0;
                    frm_d.er  = 1'b0;
                end else begin
                    frm_d.st  = ST_FLUSH;
                    frm_d.rxd = NIB_FALSE_CS;
                    frm_d.er  = 1'b1;
                end
            end
        end else begin
            frm_d.cnt = sym_edge ? '0 : frm_q.cnt + 1'b1;
            if (sym_edge) begin
                frm_d.stb = 1'b1;
                case (frm_q.st)
                    ST_CHK_K: begin
                        if (cls.is_k) begin
                            frm_d.st   = ST_DATA;
                            frm_d.rxd  = NIB_PREAMBLE;
                            frm_d.dv   = 1'b1;
                            frm_d.er   = 1'b0;
                            frm_d.pend = NIB_PREAMBLE;
                            frm_d.perr = 1'b0;
                        end else begin
                            frm_d.st  = ST_FLUSH;
                            frm_d.rxd = NIB_FALSE_CS;
                            frm_d.dv  = 1'b0;
                            frm_d.er  = 1'b1;
                        end
                    end
                    ST_DATA: begin
                        frm_d.rxd = frm_q.pend;
                        frm_d.dv  = 1'b1;
                        if (cls.is_t) begin
                            frm_d.st = ST_CHK_R;
                            frm_d.er = frm_q.perr;
                        end else if (cls.is_idle) begin
                            frm_d.st = ST_FLUSH;
                            frm_d.er = 1'b1;
                            prem_set = 1'b1;
                        end else begin
                            frm_d.er   = frm_q.perr;
                            frm_d.pend = cls.is_data ? cls.nib : '0;
                            frm_d.perr = ~cls.is_data;
                        end
                    end
                    ST_CHK_R: begin
                        if (cls.is_r) begin
                            frm_d.st  = ST_IDLE;
                            frm_d.rxd = '0;
                            frm_d.dv  = 1'b0;
                            frm_d.er  = 1'b0;
                            frm_d.crs = 1'b0;
                            clr_win   = 1'b1;
                        end else begin
                            frm_d.st  = ST_FLUSH;
                            frm_d.rxd = '0;
                            frm_d.dv  = 1'b1;
                            frm_d.er  = 1'b1;
                        end
                    end
                    default: begin
                        frm_d.st  = ST_IDLE;
                        frm_d.rxd = '0;
                        frm_d.dv  = 1'b0;
                        frm_d.er  = 1'b0;
                        frm_d.crs = 1'b0;
                        clr_win   = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign rxd    = frm_q.rxd;
    assign rx_dv  = frm_q.dv;
    assign rx_er  = frm_q.er;
    assign crs    = frm_q.crs;
    assign rx_stb = frm_q.stb;

endmodule

// File: rtl/fe_rx_framer_chk.sv
module fe_rx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_rd,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       rx_er,
    input logic       crs,
    input logic       rx_stb,
    input logic       prem_end
);
    assert_dv_inside_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> crs);

    assert_hold_between_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_stb |-> ($stable(rxd) && $stable(rx_dv) && $stable(rx_er) && $stable(crs)));

    assert_single_cycle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb);

    assert_preamble_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> (rxd == 4'b0101));

    assert_false_carrier_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_er && !rx_dv) |-> (rxd == 4'b1110));

    assert_flag_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prem_end && !stat_rd) |=> prem_end);

    assert_flag_with_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prem_end) |-> (rx_er && rx_dv));

endmodule

bind fe_rx_framer fe_rx_framer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .crs     (crs),
    .rx_stb  (rx_stb),
    .prem_end(prem_end)
);

// File: tb/fe_rx_framer_bench.sv
`timescale 1ns/1ps
module fe_rx_framer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_bit;
    logic       stat_rd;
    logic [3:0] rxd;
    logic       rx_dv;
    logic       rx_er;
    logic       crs;
    logic       rx_stb;
    logic       prem_end;

    always #2.5 clk = ~clk;

    fe_rx_framer u_fe_rx_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_bit  (rx_bit),
        .stat_rd (stat_rd),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .crs     (crs),
        .rx_stb  (rx_stb),
        .prem_end(prem_end)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    bitq[$];
    bit    rdq[$];

    // behavioural reference state
    int    m_st;   // 0 idle, 1 expect K, 2 data, 3 expect R, 4 drain
    int    m_cnt;
    int    m_pend;
    bit    m_perr;
    int    m_win[$];
    string m_tag;
    int    e_rxd;
    bit    e_dv, e_er, e_crs, e_stb, e_flag;

    localparam int J_CODE = 5'b11000;
    localparam int K_CODE = 5'b10001;
    localparam int T_CODE = 5'b01101;
    localparam int R_CODE = 5'b00111;
    localparam int I_CODE = 5'b11111;

    function automatic int enc(int v);
        case (v)
            0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
            4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
            8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
            12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    function automatic int dec(int s);
        for (int v = 0; v < 16; v++) begin
            if (enc(v) == s) return v;
        end
        return -1;
    endfunction

    task automatic push_bit(bit b);
        bitq.push_back(b);
        rdq.push_back(1'b0);
    endtask

    task automatic push_sym(int c);
        for (int k = 4; k >= 0; k--) push_bit(bit'((c >> k) & 1));
    endtask

    task automatic push_idle(int n);
        for (int k = 0; k < n; k++) push_sym(I_CODE);
    endtask

    task automatic mark_read();
        rdq[rdq.size() - 1] = 1'b1;
    endtask

    task automatic clear_win();
        m_win.delete();
        for (int k = 0; k < 10; k++) m_win.push_back(1);
    endtask

    task automatic to_idle(string tag);
        e_rxd = 0; e_dv = 0; e_er = 0; e_crs = 0;
        m_st  = 0;
        m_tag = tag;
        clear_win();
    endtask

    function automatic bit two_apart_zeros();
        for (int i = 0; i < 10; i++)
            for (int j = i + 2; j < 10; j++)
                if (m_win[i] == 0 && m_win[j] == 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(bit b, bit rd);
        int sym;
        int d;
        bit setf;
        setf = 1'b0;
        m_win.push_back(int'(b));
        void'(m_win.pop_front());
        sym = m_win[5] * 16 + m_win[6] * 8 + m_win[7] * 4 + m_win[8] * 2 + m_win[9];
        e_stb = 1'b0;
        if (m_st == 0) begin
            if (two_apart_zeros()) begin
                e_stb = 1'b1; e_crs = 1'b1; e_dv = 1'b0; m_cnt = 0;
                if (sym == J_CODE) begin
                    e_rxd = 0; e_er = 0; m_st = 1; m_tag = "R2";
                end else begin
                    e_rxd = 14; e_er = 1; m_st = 4; m_tag = "R8";
                end
            end
        end else if (m_cnt < 4) begin
            m_cnt++;
        end else begin
            m_cnt = 0;
            e_stb = 1'b1;
            case (m_st)
                1: begin
                    if (sym == K_CODE) begin
                        e_rxd = 5; e_dv = 1; e_er = 0; m_pend = 5; m_perr = 0; m_st = 2; m_tag = "R3";
                    end else begin
                        e_rxd = 14; e_dv = 0; e_er = 1; m_st = 4; m_tag = "R8";
                    end
                end
                2: begin
                    e_rxd = m_pend; e_dv = 1;
                    if (sym == T_CODE) begin
                        e_er = m_perr; m_st = 3; m_tag = m_perr ? "R6" : "R5";
                    end else if (sym == I_CODE) begin
                        e_er = 1; setf = 1; m_st = 4; m_tag = "R7";
                    end else begin
                        e_er = m_perr;
                        m_tag = m_perr ? "R6" : "R4";
                        d = dec(sym);
                        m_pend = (d < 0) ? 0 : d;
                        m_perr = (d < 0);
                    end
                end
                3: begin
                    if (sym == R_CODE) begin
                        to_idle("R5");
                    end else begin
                        e_rxd = 0; e_dv = 1; e_er = 1; m_st = 4; m_tag = "R9";
                    end
                end
                default: to_idle("R11");
            endcase
        end
        e_flag = setf | (e_flag & !rd);
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(m_tag, "rxd",    int'(rxd),    e_rxd);
        check(m_tag, "rx_dv",  int'(rx_dv),  int'(e_dv));
        check(m_tag, "rx_er",  int'(rx_er),  int'(e_er));
        check(m_tag, "crs",    int'(crs),    int'(e_crs));
        check(m_tag, "rx_stb", int'(rx_stb), int'(e_stb));
        check("R10", "prem_end", int'(prem_end), int'(e_flag));
    endtask

    task automatic build_stimulus();
        // R4: normal frame carrying all sixteen data values
        push_idle(4);
        push_sym(J_CODE); push_sym(K_CODE);
        for (int v = 0; v < 16; v++) push_sym(enc(v));
        push_sym(T_CODE); push_sym(R_CODE);
        push_idle(3);
        // R6: undecodable group inside a frame
        push_sym(J_CODE); push_sym(K_CODE);
        push_sym(enc(5)); push_sym(enc(10)); push_sym(5'b00100); push_sym(enc(3));
        push_sym(T_CODE); push_sym(R_CODE);
        push_idle(3);
        // R11: single zero right after a frame end starts nothing
        push_sym(J_CODE); push_sym(K_CODE); push_sym(enc(1));
        push_sym(T_CODE); push_sym(R_CODE);
        push_bit(1); push_bit(0); push_bit(1); push_bit(1); push_bit(1);
        push_idle(3);
        // R7: premature end, then a later read clears the flag (R10)
        push_sym(J_CODE); push_sym(K_CODE); push_sym(enc(7)); push_sym(enc(8));
        push_sym(I_CODE);
        push_idle(3);
        push_bit(1); mark_read();
        push_idle(2);
        // R10: read coinciding with a new premature end keeps the flag
        push_sym(J_CODE); push_sym(K_CODE); push_sym(enc(9));
        push_sym(I_CODE); mark_read();
        push_idle(4);
        push_bit(1); mark_read();
        push_idle(2);
        // R8: carrier without a leading J
        push_bit(1); push_bit(0); push_bit(1); push_bit(0);
        push_idle(4);
        // R8: J followed by something other than K
        push_sym(J_CODE); push_sym(enc(3));
        push_idle(4);
        // R9: T followed by something other than R
        push_sym(J_CODE); push_sym(K_CODE); push_sym(enc(2));
        push_sym(T_CODE); push_sym(enc(0));
        push_idle(4);
        // R11 and R2: back-to-back frames with no idle gap
        push_sym(J_CODE); push_sym(K_CODE); push_sym(enc(4));
        push_sym(T_CODE); push_sym(R_CODE);
        push_sym(J_CODE); push_sym(K_CODE); push_sym(enc(6));
        push_sym(T_CODE); push_sym(R_CODE);
        push_idle(4);
    endtask

    initial begin
        rst_n   = 1'b0;
        rx_bit  = 1'b1;
        stat_rd = 1'b0;
        build_stimulus();
        clear_win();
        m_st = 0; m_cnt = 0; m_pend = 0; m_perr = 0; m_tag = "R1";
        e_rxd = 0; e_dv = 0; e_er = 0; e_crs = 0; e_stb = 0; e_flag = 0;
        repeat (4) @(negedge clk);
        compare_all();          // R1 while reset is held
        rst_n = 1'b1;
        for (int i = 0; i < bitq.size(); i++) begin
            rx_bit  = bitq[i];
            stat_rd = rdq[i];
            step(bitq[i], rdq[i]);
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule